// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block runs one programmed-I/O access on a parallel ATA device bus. A host
asks for a register access or a data-word access to one of two attached devices,
and the block drives the address lines and chip selects. It then pulses the read
or write strobe and either drives the write data or captures the read data. Every
phase is timed from a per-device timing word counted in system clock cycles.

Each device has two timing words. One is used for register (command) accesses and
one for data accesses. Every word holds four 8-bit counts stored as "clocks minus
one". These counts time the address setup phase, the strobe pulse, the data hold
phase and a trailing recovery gap before the next access may start. A device that
needs more time can pull its ready line low to stretch the strobe, and each device
has its own enable for this. A control word also terminates a running access,
raises a termination interrupt, and drives the device hard-reset and soft-reset
lines.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset both strobes and both chip selects are high (inactive), `req_ready` is 1, and `done` and `term_irq` are 0.
- R2: The four phases run in this order: setup (strobe high, selects active), strobe, hold, recovery. The counts sit in the timing word as setup in [7:0], strobe in [15:8], hold in [23:16] and recovery in [31:24]. Each phase lasts its field value plus one clock, so a zero field still gives one clock.
- R3: A register access (`req_data`=0) uses the command timing word of the device on `req_dev`. A data access (`req_data`=1) uses that device's data timing word.
- R4: Through all four phases `ata_cs_n` equals the inverse of `req_cs` and `ata_addr` equals `req_addr`. Outside an access both selects are high. A read pulses only `ata_dior_n`, a write pulses only `ata_diow_n`, and the two are never low together.
- R5: On a read, `rd_data` takes the value `ata_din` had in the last strobe clock, at the edge where the strobe rises. It keeps that value until the next read.
- R6: On a write, `ata_doe` is 1 and `ata_dout` carries `req_wdata` from the first setup clock to the last hold clock. `ata_doe` is 0 during recovery.
- R7: When the ready-wait enable of the accessed device is set, the strobe does not end while `ata_iordy` is low. Control bit 3 enables this for device 0 and bit 19 for device 1. With the enable clear, `ata_iordy` has no effect.
- R8: `done` is high for exactly one clock, the first idle clock after recovery. It stays low during the access.
- R9: Setting control bit 29 during an access returns the bus to idle at the next edge, and that access gives no `done`. If control bit 28 is also set, `term_irq` pulses for one clock. If bit 28 is clear, `term_irq` stays low.
- R10: `dev_hard_rst` follows control bit 31 and `dev_soft_rst` follows control bit 30, held for as long as the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Control: wait enables, termination, interrupt enable, device resets |
| tim_cmd0 | input | 32 | Device 0 register-access timing word |
| tim_dat0 | input | 32 | Device 0 data-access timing word |
| tim_cmd1 | input | 32 | Device 1 register-access timing word |
| tim_dat1 | input | 32 | Device 1 data-access timing word |
| req_valid | input | 1 | Start an access (taken when `req_ready` is 1) |
| req_ready | output | 1 | Block is idle and can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data access, 0 = register access |
| req_dev | input | 1 | Device number |
| req_addr | input | 3 | Register address |
| req_cs | input | 2 | Chip selects, active high |
| req_wdata | input | 16 | Write data |
| ata_addr | output | 3 | Device address lines |
| ata_cs_n | output | 2 | Device chip selects, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Write data to the bus |
| ata_doe | output | 1 | Bus output enable |
| ata_din | input | 16 | Read data from the bus |
| ata_iordy | input | 1 | Device ready, low to stretch the strobe |
| dev_hard_rst | output | 1 | Device hard reset line |
| dev_soft_rst | output | 1 | Device soft reset line |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-clock access completion pulse |
| term_irq | output | 1 | One-clock termination interrupt pulse |

## Verification
A request taken at edge E0 puts the bus in setup from E0 onward. The strobe starts
after setup+1 clocks, and `done` and the captured data appear in the first clock
after the last recovery clock. The whole access therefore takes setup+strobe+hold+recovery+4
clocks. The bench samples every clock of an access between edges and classifies it
by the strobe and output-enable pins. It checks each phase length against its field
plus one, and it changes `ata_din` in the first clock after the strobe, so a late
capture is caught. A termination shows its result one edge later, and a ready-line
release lets the strobe end at the edge that follows it.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_RECOV  = 3'd4
   } phase_e;

   localparam int FIELD_COUNT = 4;
endpackage

// File: rtl/ata_pio_tim_sel.sv
module ata_pio_tim_sel #(
   parameter int TIM_W   = 32,
   parameter int NUM_DEV = 2,
   localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic [NUM_DEV-1:0][TIM_W-1:0] cmd_set,
   input  logic [NUM_DEV-1:0][TIM_W-1:0] dat_set,
   input  logic [DEV_W-1:0]              dev,
   input  logic                          use_data,
   output logic [TIM_W-1:0]              tim
);
   always_comb begin
      tim = use_data ? dat_set[dev] : cmd_set[dev];
   end
endmodule

// File: rtl/ata_pio_phase_fsm.sv
module ata_pio_phase_fsm
   import ata_pio_pkg::*;
#(
   parameter int CNT_W = 8,
   localparam int TIM_W = FIELD_COUNT * CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             wait_rdy,
   input  logic [TIM_W-1:0] tim,
   output phase_e           phase,
   output logic             strobe_end,
   output logic             done
);
   logic [TIM_W-1:0] snap;
   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;

   assign cnt_zero   = (cnt == '0);
   assign strobe_end = (phase == PH_STROBE) && cnt_zero && !wait_rdy && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         snap  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  snap  <= tim;
                  cnt   <= tim[0*CNT_W +: CNT_W];
                  phase <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  cnt   <= snap[1*CNT_W +: CNT_W];
                  phase <= PH_STROBE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (cnt_zero) begin
                  if (!wait_rdy) begin
                     cnt   <= snap[2*CNT_W +: CNT_W];
                     phase <= PH_HOLD;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_zero) begin
                  cnt   <= snap[3*CNT_W +: CNT_W];
                  phase <= PH_RECOV;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_RECOV: begin
               if (cnt_zero) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
         if (abort && phase != PH_IDLE) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
   import ata_pio_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 3,
   parameter int CS_W         = 2,
   parameter int CNT_W        = 8,
   parameter int CTRL_W       = 32,
   parameter int RDY_EN_BIT   = 3,
   parameter int DEV_STRIDE   = 16,
   parameter int ABORT_IE_BIT = 28,
   parameter int ABORT_BIT    = 29,
   parameter int SRST_BIT     = 30,
   parameter int HRST_BIT     = 31,
   localparam int TIM_W       = FIELD_COUNT * CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic [TIM_W-1:0]  tim_cmd0,
   input  logic [TIM_W-1:0]  tim_dat0,
   input  logic [TIM_W-1:0]  tim_cmd1,
   input  logic [TIM_W-1:0]  tim_dat1,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_data,
   input  logic              req_dev,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] ata_addr,
   output logic [CS_W-1:0]   ata_cs_n,
   output logic              ata_dior_n,
   output logic              ata_diow_n,
   output logic [DATA_W-1:0] ata_dout,
   output logic              ata_doe,
   input  logic [DATA_W-1:0] ata_din,
   input  logic              ata_iordy,
   output logic              dev_hard_rst,
   output logic              dev_soft_rst,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              term_irq
);
   localparam int NUM_DEV = 2;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
      if (HRST_BIT >= CTRL_W || SRST_BIT >= CTRL_W || ABORT_BIT >= CTRL_W ||
          ABORT_IE_BIT >= CTRL_W) begin : g_bad_ctrl
         $error("control bit position outside the control word");
      end
      if (RDY_EN_BIT + DEV_STRIDE * (NUM_DEV - 1) >= CTRL_W) begin : g_bad_rdy
         $error("ready-wait enable bit outside the control word");
      end
   endgenerate

   phase_e                          phase;
   logic                            strobe_end;
   logic                            fsm_done;
   logic                            abort;
   logic                            active;
   logic                            start;
   logic                            wait_rdy;
   logic                            cur_rdy_en;
   logic [NUM_DEV-1:0]              rdy_en;
   logic [NUM_DEV-1:0][TIM_W-1:0]   cmd_set;
   logic [NUM_DEV-1:0][TIM_W-1:0]   dat_set;
   logic [TIM_W-1:0]                tim_pick;

   logic              lat_write;
   logic              lat_dev;
   logic [ADDR_W-1:0] lat_addr;
   logic [CS_W-1:0]   lat_cs;
   logic [DATA_W-1:0] lat_wdata;

   // Per-device ready-wait enables sit at a fixed stride in the control word
   for (genvar d = 0; d < NUM_DEV; d++) begin : g_rdy
      assign rdy_en[d] = ctrl_word[RDY_EN_BIT + d * DEV_STRIDE];
   end

   assign cmd_set = {tim_cmd1, tim_cmd0};
   assign dat_set = {tim_dat1, tim_dat0};

   assign abort      = ctrl_word[ABORT_BIT];
   assign active     = (phase != PH_IDLE);
   assign req_ready  = !active && !abort;
   assign start      = req_valid && req_ready;
   assign cur_rdy_en = rdy_en[lat_dev];
   assign wait_rdy   = cur_rdy_en && !ata_iordy;

   ata_pio_tim_sel #(.TIM_W(TIM_W), .NUM_DEV(NUM_DEV)) u_sel (
      .cmd_set  (cmd_set),
      .dat_set  (dat_set),
      .dev      (req_dev),
      .use_data (req_data),
      .tim      (tim_pick)
   );

   ata_pio_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .abort      (abort),
      .wait_rdy   (wait_rdy),
      .tim        (tim_pick),
      .phase      (phase),
      .strobe_end (strobe_end),
      .done       (fsm_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_write <= 1'b0;
         lat_dev   <= 1'b0;
         lat_addr  <= '0;
         lat_cs    <= '0;
         lat_wdata <= '0;
      end else if (start) begin
         lat_write <= req_write;
         lat_dev   <= req_dev;
         lat_addr  <= req_addr;
         lat_cs    <= req_cs;
         lat_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         term_irq <= 1'b0;
      end else begin
         if (strobe_end && !lat_write) begin
            rd_data <= ata_din;
         end
         term_irq <= abort && active && ctrl_word[ABORT_IE_BIT];
      end
   end

   always_comb begin
      ata_addr   = active ? lat_addr : '0;
      ata_cs_n   = active ? ~lat_cs : '1;
      ata_dior_n = !(phase == PH_STROBE && !lat_write);
      ata_diow_n = !(phase == PH_STROBE && lat_write);
      ata_doe    = active && lat_write && (phase != PH_RECOV);
      ata_dout   = lat_wdata;
   end

   assign done         = fsm_done;
   assign dev_hard_rst = ctrl_word[HRST_BIT];
   assign dev_soft_rst = ctrl_word[SRST_BIT];
endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk #(
   parameter int CS_W         = 2,
   parameter int CTRL_W       = 32,
   parameter int ABORT_BIT    = 29,
   parameter int ABORT_IE_BIT = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic [CS_W-1:0]   ata_cs_n,
   input logic              ata_dior_n,
   input logic              ata_diow_n,
   input logic              ata_doe,
   input logic              ata_iordy,
   input logic              cur_rdy_en,
   input logic              done,
   input logic              term_irq
);
   logic strobe_on;
   logic bus_active;
   assign strobe_on  = !ata_dior_n || !ata_diow_n;
   assign bus_active = (ata_cs_n != '1);

   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_dior_n && !ata_diow_n));

   p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_diow_n |-> ata_doe);

   p_done_after_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!bus_active && $past(bus_active)));

   p_iordy_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_on && cur_rdy_en && !ata_iordy && !ctrl_word[ABORT_BIT]) |=> strobe_on);

   p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[ABORT_BIT] && bus_active) |=> (!bus_active && !done));

   p_term_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      term_irq |-> $past(ctrl_word[ABORT_BIT] && ctrl_word[ABORT_IE_BIT] && bus_active));
endmodule

bind ata_pio_timer ata_pio_timer_chk #(
   .CS_W         (CS_W),
   .CTRL_W       (CTRL_W),
   .ABORT_BIT    (ABORT_BIT),
   .ABORT_IE_BIT (ABORT_IE_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_word  (ctrl_word),
   .ata_cs_n   (ata_cs_n),
   .ata_dior_n (ata_dior_n),
   .ata_diow_n (ata_diow_n),
   .ata_doe    (ata_doe),
   .ata_iordy  (ata_iordy),
   .cur_rdy_en (cur_rdy_en),
   .done       (done),
   .term_irq   (term_irq)
);

// File: tb/ata_pio_timer_tb.sv
module ata_pio_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl_word = '0;
   logic [31:0] tim_cmd0 = '0, tim_dat0 = '0, tim_cmd1 = '0, tim_dat1 = '0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_data = 1'b0, req_dev = 1'b0;
   logic [2:0]  req_addr = '0;
   logic [1:0]  req_cs = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [2:0]  ata_addr;
   logic [1:0]  ata_cs_n;
   logic        ata_dior_n, ata_diow_n, ata_doe;
   logic [15:0] ata_dout;
   logic [15:0] ata_din = '0;
   logic        ata_iordy = 1'b1;
   logic        dev_hard_rst, dev_soft_rst, done, term_irq;
   logic [15:0] rd_data;

   int checks = 0;
   int fails  = 0;

   // measured by run_access
   int m_setup, m_strobe, m_post, m_doe_post, m_bad;
   bit m_done, m_done_early;

   always #10 clk = ~clk;

   ata_pio_timer u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
      .tim_cmd0(tim_cmd0), .tim_dat0(tim_dat0), .tim_cmd1(tim_cmd1), .tim_dat1(tim_dat1),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_data(req_data), .req_dev(req_dev), .req_addr(req_addr), .req_cs(req_cs),
      .req_wdata(req_wdata), .ata_addr(ata_addr), .ata_cs_n(ata_cs_n),
      .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dout(ata_dout),
      .ata_doe(ata_doe), .ata_din(ata_din), .ata_iordy(ata_iordy),
      .dev_hard_rst(dev_hard_rst), .dev_soft_rst(dev_soft_rst),
      .rd_data(rd_data), .done(done), .term_irq(term_irq)
   );

   function automatic logic [31:0] tw(input int s, input int w, input int h, input int r);
      return {r[7:0], h[7:0], w[7:0], s[7:0]};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Issue one access and classify every clock of it at the ports
   task automatic run_access(input bit wr, input bit dat, input bit dev,
                             input logic [2:0] addr, input logic [1:0] cs,
                             input logic [15:0] wdata, input logic [15:0] din_a,
                             input logic [15:0] din_b, input int release_k);
      m_setup = 0; m_strobe = 0; m_post = 0; m_doe_post = 0; m_bad = 0;
      m_done = 0; m_done_early = 0;
      @(negedge clk);
      ata_din   = din_a;
      ata_iordy = (release_k == 0);
      req_valid = 1'b1; req_write = wr; req_data = dat; req_dev = dev;
      req_addr = addr; req_cs = cs; req_wdata = wdata;
      @(negedge clk);
      req_valid = 1'b0;
      for (int g = 0; g < 1000 && ata_cs_n != 2'b11; g++) begin
         if (ata_addr != addr || ata_cs_n != ~cs) m_bad++;
         if (done) m_done_early = 1;
         if (!ata_dior_n || !ata_diow_n) begin
            if (wr ? !ata_dior_n : !ata_diow_n) m_bad++;
            if (wr && (!ata_doe || ata_dout != wdata)) m_bad++;
            m_strobe++;
            if (release_k > 0 && m_strobe == release_k) ata_iordy = 1'b1;
         end else if (m_strobe == 0) begin
            if (wr && !ata_doe) m_bad++;
            m_setup++;
         end else begin
            if (m_post == 0) ata_din = din_b;
            m_post++;
            if (ata_doe) m_doe_post++;
         end
         @(negedge clk);
      end
      m_done = done;
      ata_iordy = 1'b1;
   endtask

   task automatic t_reset;
      chk("R1 dior_n", ata_dior_n, 1);
      chk("R1 diow_n", ata_diow_n, 1);
      chk("R1 cs_n", ata_cs_n, 3);
      chk("R1 ready", req_ready, 1);
      chk("R1 done", done, 0);
      chk("R1 term_irq", term_irq, 0);
   endtask

   task automatic t_reg_read;
      tim_cmd0 = tw(1, 4, 2, 3);
      tim_dat0 = tw(7, 7, 7, 7);
      run_access(0, 0, 0, 3'd5, 2'b01, 16'h0, 16'hA5C3, 16'h1111, 0);
      chk("R2 setup clocks", m_setup, 2);
      chk("R3 R2 strobe clocks cmd set", m_strobe, 5);
      chk("R2 hold+recovery clocks", m_post, 7);
      chk("R4 address and selects", m_bad, 0);
      chk("R5 read capture at strobe end", rd_data, 16'hA5C3);
      chk("R8 done pulse", m_done, 1);
      chk("R8 no early done", m_done_early, 0);
      @(negedge clk);
      chk("R8 done one clock", done, 0);
   endtask

   task automatic t_data_write;
      tim_dat0 = tw(0, 0, 1, 2);
      run_access(1, 1, 0, 3'd0, 2'b10, 16'hBEEF, 16'h0, 16'h0, 0);
      chk("R3 setup data set", m_setup, 1);
      chk("R3 strobe data set", m_strobe, 1);
      chk("R6 doe through hold", m_doe_post, 2);
      chk("R6 recovery without doe", m_post - m_doe_post, 3);
      chk("R6 R4 write drive and strobe", m_bad, 0);
      chk("R5 rd_data kept on write", rd_data, 16'hA5C3);
   endtask

   task automatic t_dev1_sets;
      tim_cmd1 = tw(3, 2, 0, 0);
      tim_dat1 = tw(0, 6, 1, 1);
      run_access(0, 1, 1, 3'd0, 2'b01, 16'h0, 16'h5A5A, 16'h0F0F, 0);
      chk("R3 dev1 data setup", m_setup, 1);
      chk("R3 dev1 data strobe", m_strobe, 7);
      chk("R5 dev1 read", rd_data, 16'h5A5A);
      run_access(0, 0, 1, 3'd7, 2'b11, 16'h0, 16'h0001, 16'h0002, 0);
      chk("R3 dev1 cmd setup", m_setup, 4);
      chk("R3 dev1 cmd strobe", m_strobe, 3);
      chk("R2 dev1 cmd post", m_post, 2);
   endtask

   task automatic t_zero_fields;
      tim_cmd0 = tw(0, 0, 0, 0);
      run_access(0, 0, 0, 3'd1, 2'b01, 16'h0, 16'h7E7E, 16'h0, 0);
      chk("R2 zero setup", m_setup, 1);
      chk("R2 zero strobe", m_strobe, 1);
      chk("R2 zero post", m_post, 2);
      chk("R8 zero done", m_done, 1);
   endtask

   task automatic t_iordy;
      tim_cmd0 = tw(0, 1, 0, 0);
      tim_cmd1 = tw(0, 1, 0, 0);
      ctrl_word = 32'h0000_0008;
      run_access(0, 0, 0, 3'd2, 2'b01, 16'h0, 16'h1234, 16'h4321, 6);
      chk("R7 dev0 stretched strobe", m_strobe, 6);
      chk("R7 dev0 capture after wait", rd_data, 16'h1234);
      run_access(0, 0, 1, 3'd2, 2'b01, 16'h0, 16'h0, 16'h0, 6);
      chk("R7 dev1 wait ignored when bit19 clear", m_strobe, 2);
      ctrl_word = 32'h0008_0000;
      run_access(1, 0, 1, 3'd2, 2'b01, 16'h9999, 16'h0, 16'h0, 6);
      chk("R7 dev1 stretched strobe", m_strobe, 6);
      run_access(1, 0, 0, 3'd2, 2'b01, 16'h9999, 16'h0, 16'h0, 6);
      chk("R7 dev0 wait ignored when bit3 clear", m_strobe, 2);
      ctrl_word = '0;
   endtask

   task automatic t_abort(input bit irq_en);
      tim_cmd0 = tw(10, 10, 10, 10);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_data = 1'b0; req_dev = 1'b0;
      req_cs = 2'b01; req_addr = 3'd4;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 access running", ata_cs_n, 2'b10);
      ctrl_word = irq_en ? 32'h3000_0000 : 32'h2000_0000;
      @(negedge clk);
      chk("R9 bus idle after terminate", ata_cs_n, 3);
      chk("R9 term_irq level", term_irq, irq_en);
      chk("R9 no done on terminate", done, 0);
      ctrl_word = '0;
      @(negedge clk);
      chk("R9 term_irq one clock", term_irq, 0);
      chk("R9 no late done", done, 0);
      chk("R9 ready again", req_ready, 1);
   endtask

   task automatic t_resets;
      ctrl_word = 32'h8000_0000;
      @(negedge clk);
      chk("R10 hard reset on", dev_hard_rst, 1);
      chk("R10 soft reset off", dev_soft_rst, 0);
      ctrl_word = 32'h4000_0000;
      @(negedge clk);
      chk("R10 hard reset released", dev_hard_rst, 0);
      chk("R10 soft reset on", dev_soft_rst, 1);
      ctrl_word = '0;
      @(negedge clk);
      chk("R10 soft reset released", dev_soft_rst, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reg_read();
      t_data_write();
      t_dev1_sets();
      t_zero_fields();
      t_iordy();
      t_abort(1'b1);
      t_abort(1'b0);
      t_resets();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule